// File: doc/BRIEF.md
# Serial Register Port with Command Byte

This block is a synchronous serial slave that gives a host access to a small register file over four wires: a serial clock, a data input, a data output and an active-low chip select. The port runs in the fabric clock domain. It passes the serial pins through a short synchronizer and acts on the detected serial-clock edges. Input bits are taken on rising serial-clock edges. The output bit is updated after falling edges.

Every access opens with an eight-bit command byte, sent most significant bit first. The leading gate bit must be 0. While the port sees 1 there, it waits in place, so idle-high lines never start a command. The remaining seven bits carry the following fields:
- the direction of the access;
- a low-power request;
- a request to also stop the oscillator while in low power;
- two reserved bits, which must be 0;
- a two-bit register selector.

After the command byte comes a data phase of 8, 16 or 24 bits, depending on the register. The port then waits for the next command.

A run of 32 consecutive ones on the data input restores the interface and the writable registers to their defaults. This lets a host recover after losing track of the framing. Conversion results enter on a parallel input. The status byte enters on a second parallel input.

Top module: `regport_serial`

## Requirements
- R1: After the synchronous reset, the port is in the following state: `dout` = 0, `dout_en` = 0, `cfg_q` = 0x000000, `filt_q` = 0x45, `standby` = 0 and `osc_stop` = 0.
- R2: While the port waits for a command, each serial bit of 1 is discarded. The first 0 starts the command byte, and the next seven bits complete it.
- R3: The command byte is laid out as follows: bit 7 is the gate, bit 6 selects the direction (1 = read), bit 5 is the low-power request and bit 4 is the oscillator stop. Every accepted command byte copies bit 5 to `standby` and bit 4 to `osc_stop`.
- R4: A command byte whose bits 3:2 are not 00 has no effect. The following conditions then hold:
  - `standby`, `osc_stop` and the registers are unchanged.
  - The port goes back to waiting for a gate bit of 0.
- R5: Writes use the selector in bits 1:0. A write to selector 01 takes 24 bits into `cfg_q`. A write to selector 10 takes 8 bits into `filt_q`. Both are sent MSB first, and the register updates only when the last bit has arrived. A write to selector 00 is the command byte itself and has no data phase.
- R6: Reads return the following, MSB first:
  - selector 00: `status_in` (8 bits);
  - selector 01: `cfg_q` (24 bits);
  - selector 10: `filt_q` (8 bits);
  - selector 11: `conv_data` (16 bits).

  Each bit is valid on `dout` from the falling serial-clock edge before the rising edge that would sample it. `dout_en` is 1 only during a read data phase. Outside a read data phase, `dout` is 0.
- R7: A write to selector 11 is accepted for its 16-bit phase, but its bits are discarded. `cfg_q` and `filt_q` keep their values.
- R8: After a data phase completes, the next bit is treated as a gate bit. Transactions may follow each other without releasing chip select.
- R9: Thirty-two consecutive rising serial-clock edges with the data input high, with chip select held low, restore all registers and control outputs to their R1 values. A run of 31 has no effect.
- R10: Raising `cs_n` during a transaction aborts it, and a partially shifted write is not committed. The next transaction starts from the gate bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fabric clock |
| rst | input | 1 | Synchronous active-high reset |
| cs_n | input | 1 | Active-low chip select |
| sclk | input | 1 | Serial clock, idle low |
| din | input | 1 | Serial data from host |
| status_in | input | 8 | Status byte returned by reads of selector 00 |
| conv_data | input | 16 | Conversion result returned by reads of selector 11 |
| dout | output | 1 | Serial data to host, 0 outside read phases |
| dout_en | output | 1 | High during a read data phase |
| cfg_q | output | 24 | Configuration register |
| filt_q | output | 8 | Filter-rate register |
| standby | output | 1 | Low-power request from last accepted command |
| osc_stop | output | 1 | Oscillator-stop request from last accepted command |

## Verification
The hardest situation to bring about is the recovery run. Only an unbroken string of 32 rising edges with the data input high may fire it. Every legal command carries a 0 gate bit, so ordinary traffic always breaks the run.

The stimulus first sets `standby`, `cfg_q` and `filt_q` to non-default values. It then sends exactly 31 ones, releases chip select and checks that nothing changed. Only after that does it send the full 32.

A second hard case is the abort. Here chip select is dropped in the middle of a 24-bit write. The bench then reads the register back through the port to show that the partial write was not committed.

// File: rtl/regport_pkg.sv
package regport_pkg;
  // Serial interface state
  typedef enum logic [1:0] {
    ST_GATE = 2'd0,  // waiting for a 0 gate bit
    ST_CMD  = 2'd1,  // collecting the seven command bits
    ST_WR   = 2'd2,  // write data phase
    ST_RD   = 2'd3   // read data phase
  } port_state_t;

  // Register selector codes (bits 1:0 of the command byte)
  localparam logic [1:0] SEL_CTRL = 2'b00;  // command on write, status on read
  localparam logic [1:0] SEL_CFG  = 2'b01;
  localparam logic [1:0] SEL_FLT  = 2'b10;
  localparam logic [1:0] SEL_CONV = 2'b11;

  // Command byte bit positions below the gate bit
  localparam int CMD_BITS   = 7;
  localparam int CB_DIR     = 6;
  localparam int CB_STBY    = 5;
  localparam int CB_OSC     = 4;
endpackage

// File: rtl/regport_sync.sv
module regport_sync #(
  parameter int W = 3,
  parameter int STAGES = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] pipe [STAGES];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < STAGES; i++) pipe[i] <= RST_VAL;
    end else begin
      pipe[0] <= d;
      for (int i = 1; i < STAGES; i++) pipe[i] <= pipe[i-1];
    end
  end

  assign q = pipe[STAGES-1];
endmodule

// File: rtl/regport_ones.sv
module regport_ones #(
  parameter int ONES_RESET = 32
) (
  input  logic clk,
  input  logic rst,
  input  logic csn_s,
  input  logic rise,
  input  logic din_s,
  output logic fire
);
  localparam int CW = $clog2(ONES_RESET + 1);

  logic [CW-1:0] run_cnt;

  always_ff @(posedge clk) begin
    if (rst || csn_s) begin
      run_cnt <= '0;
    end else if (rise) begin
      if (!din_s) run_cnt <= '0;
      else if (run_cnt != CW'(ONES_RESET)) run_cnt <= run_cnt + CW'(1);
    end
  end

  assign fire = rise && din_s && !csn_s && (run_cnt == CW'(ONES_RESET - 1));

  // R9: a run fires the recovery only once; further ones saturate
  p_fire_once_r9: assert property (@(posedge clk) disable iff (rst)
    fire |=> !fire);
endmodule

// File: rtl/regport_fsm.sv
module regport_fsm
  import regport_pkg::*;
#(
  parameter int SH_W  = 24,
  parameter int CFG_W = 24,
  parameter int FLT_W = 8,
  parameter int DAT_W = 16,
  parameter int STS_W = 8
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            soft_rst,
  input  logic            csn_s,
  input  logic            din_s,
  input  logic            rise,
  input  logic            fall,
  input  logic [SH_W-1:0] rd_word,
  output logic [1:0]      peek_sel,
  output logic            cmd_stb,
  output logic            cmd_stby,
  output logic            cmd_osc,
  output logic            wr_stb,
  output logic [1:0]      wr_sel,
  output logic [SH_W-1:0] wr_data,
  output logic            dout,
  output logic            dout_en
);
  localparam int LEN_W = $clog2(SH_W + 1);

  port_state_t           state;
  logic [CMD_BITS-2:0]   cmd_sh;
  logic [CMD_BITS-1:0]   cmd_full;
  logic [LEN_W-1:0]      bit_cnt;
  logic [LEN_W-1:0]      len_q;
  logic [LEN_W-1:0]      phase_len;
  logic [SH_W-1:0]       sh_in;
  logic [SH_W-1:0]       sh_out;
  logic                  cmd_bad;
  logic                  last_bit;

  assign cmd_full = {cmd_sh, din_s};
  assign cmd_bad  = |cmd_full[3:2];
  assign peek_sel = cmd_full[1:0];
  assign last_bit = (bit_cnt == len_q - LEN_W'(1));

  always_comb begin
    case (cmd_full[1:0])
      SEL_CTRL: phase_len = LEN_W'(STS_W);
      SEL_CFG:  phase_len = LEN_W'(CFG_W);
      SEL_FLT:  phase_len = LEN_W'(FLT_W);
      default:  phase_len = LEN_W'(DAT_W);
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state    <= ST_GATE;
      cmd_sh   <= '0;
      bit_cnt  <= '0;
      len_q    <= LEN_W'(STS_W);
      sh_in    <= '0;
      sh_out   <= '0;
      dout     <= 1'b0;
      cmd_stb  <= 1'b0;
      cmd_stby <= 1'b0;
      cmd_osc  <= 1'b0;
      wr_stb   <= 1'b0;
      wr_sel   <= SEL_CTRL;
      wr_data  <= '0;
    end else begin
      cmd_stb <= 1'b0;
      wr_stb  <= 1'b0;
      if (soft_rst || csn_s) begin
        state   <= ST_GATE;
        bit_cnt <= '0;
        dout    <= 1'b0;
      end else begin
        case (state)
          ST_GATE: begin
            if (rise && !din_s) begin
              state   <= ST_CMD;
              bit_cnt <= '0;
            end
          end
          ST_CMD: begin
            if (rise) begin
              cmd_sh <= cmd_full[CMD_BITS-2:0];
              if (bit_cnt == LEN_W'(CMD_BITS - 1)) begin
                bit_cnt <= '0;
                if (cmd_bad) begin
                  state <= ST_GATE;
                end else begin
                  cmd_stb  <= 1'b1;
                  cmd_stby <= cmd_full[CB_STBY];
                  cmd_osc  <= cmd_full[CB_OSC];
                  wr_sel   <= cmd_full[1:0];
                  len_q    <= phase_len;
                  if (cmd_full[CB_DIR]) begin
                    state  <= ST_RD;
                    sh_out <= rd_word;
                  end else if (cmd_full[1:0] == SEL_CTRL) begin
                    state <= ST_GATE;
                  end else begin
                    state <= ST_WR;
                  end
                end
              end else begin
                bit_cnt <= bit_cnt + LEN_W'(1);
              end
            end
          end
          ST_WR: begin
            if (rise) begin
              sh_in <= {sh_in[SH_W-2:0], din_s};
              if (last_bit) begin
                wr_stb  <= 1'b1;
                wr_data <= {sh_in[SH_W-2:0], din_s};
                state   <= ST_GATE;
                bit_cnt <= '0;
              end else begin
                bit_cnt <= bit_cnt + LEN_W'(1);
              end
            end
          end
          ST_RD: begin
            if (fall) begin
              dout   <= sh_out[SH_W-1];
              sh_out <= sh_out << 1;
            end
            if (rise) begin
              if (last_bit) begin
                state   <= ST_GATE;
                bit_cnt <= '0;
                dout    <= 1'b0;
              end else begin
                bit_cnt <= bit_cnt + LEN_W'(1);
              end
            end
          end
          default: state <= ST_GATE;
        endcase
      end
    end
  end

  assign dout_en = (state == ST_RD);

  // R6: output is quiet outside read data phases
  p_dout_quiet_r6: assert property (@(posedge clk) disable iff (rst)
    (state != ST_RD) |-> !dout);
  // R10: released chip select always returns to the gate wait
  p_abort_idle_r10: assert property (@(posedge clk) disable iff (rst)
    csn_s |=> (state == ST_GATE));
  // R4: a command with nonzero reserved bits falls back to the gate wait
  p_bad_cmd_r4: assert property (@(posedge clk) disable iff (rst)
    (state == ST_CMD && rise && !csn_s && !soft_rst &&
     bit_cnt == LEN_W'(CMD_BITS - 1) && cmd_bad) |=> (state == ST_GATE && !cmd_stb));
  // R8: the bit counter stays inside the selected phase length
  p_len_r8: assert property (@(posedge clk) disable iff (rst)
    (state == ST_WR || state == ST_RD) |-> (bit_cnt < len_q));
endmodule

// File: rtl/regport_regs.sv
module regport_regs
  import regport_pkg::*;
#(
  parameter int SH_W  = 24,
  parameter int CFG_W = 24,
  parameter int FLT_W = 8,
  parameter logic [CFG_W-1:0] CFG_DEF = '0,
  parameter logic [FLT_W-1:0] FLT_DEF = 8'h45
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             soft_rst,
  input  logic             cmd_stb,
  input  logic             cmd_stby,
  input  logic             cmd_osc,
  input  logic             wr_stb,
  input  logic [1:0]       wr_sel,
  input  logic [SH_W-1:0]  wr_data,
  output logic [CFG_W-1:0] cfg_q,
  output logic [FLT_W-1:0] filt_q,
  output logic             standby,
  output logic             osc_stop
);
  always_ff @(posedge clk) begin
    if (rst || soft_rst) begin
      cfg_q    <= CFG_DEF;
      filt_q   <= FLT_DEF;
      standby  <= 1'b0;
      osc_stop <= 1'b0;
    end else begin
      if (cmd_stb) begin
        standby  <= cmd_stby;
        osc_stop <= cmd_osc;
      end
      if (wr_stb && wr_sel == SEL_CFG) cfg_q  <= wr_data[CFG_W-1:0];
      if (wr_stb && wr_sel == SEL_FLT) filt_q <= wr_data[FLT_W-1:0];
    end
  end

  // R5: the filter register changes only on its own write strobe
  p_filt_hold_r5: assert property (@(posedge clk) disable iff (rst)
    (!(wr_stb && wr_sel == SEL_FLT) && !soft_rst) |=> $stable(filt_q));
  // R7: writes to the conversion selector leave the writable registers alone
  p_conv_discard_r7: assert property (@(posedge clk) disable iff (rst)
    (wr_stb && wr_sel == SEL_CONV && !soft_rst) |=> ($stable(cfg_q) && $stable(filt_q)));
  // R9: recovery restores defaults
  p_soft_default_r9: assert property (@(posedge clk) disable iff (rst)
    soft_rst |=> (filt_q == FLT_DEF && cfg_q == CFG_DEF && !standby && !osc_stop));
endmodule

// File: rtl/regport_serial.sv
module regport_serial
  import regport_pkg::*;
#(
  parameter int CFG_W       = 24,
  parameter int FLT_W       = 8,
  parameter int DAT_W       = 16,
  parameter int STS_W       = 8,
  parameter int SYNC_STAGES = 2,
  parameter int ONES_RESET  = 32,
  parameter logic [CFG_W-1:0] CFG_DEF = '0,
  parameter logic [FLT_W-1:0] FLT_DEF = 8'h45
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             cs_n,
  input  logic             sclk,
  input  logic             din,
  input  logic [STS_W-1:0] status_in,
  input  logic [DAT_W-1:0] conv_data,
  output logic             dout,
  output logic             dout_en,
  output logic [CFG_W-1:0] cfg_q,
  output logic [FLT_W-1:0] filt_q,
  output logic             standby,
  output logic             osc_stop
);
  localparam int M1   = (CFG_W > FLT_W) ? CFG_W : FLT_W;
  localparam int M2   = (DAT_W > STS_W) ? DAT_W : STS_W;
  localparam int SH_W = (M1 > M2) ? M1 : M2;

  logic [2:0]      pins_s;
  logic            csn_s, sclk_s, din_s, sclk_d;
  logic            rise, fall, soft_rst;
  logic [1:0]      peek_sel, wr_sel;
  logic [SH_W-1:0] rd_word, wr_data;
  logic            cmd_stb, cmd_stby, cmd_osc, wr_stb;

  regport_sync #(.W(3), .STAGES(SYNC_STAGES), .RST_VAL(3'b100)) u_sync (
    .clk(clk), .rst(rst), .d({cs_n, sclk, din}), .q(pins_s));

  assign {csn_s, sclk_s, din_s} = pins_s;

  always_ff @(posedge clk) begin
    if (rst) sclk_d <= 1'b0;
    else     sclk_d <= sclk_s;
  end

  assign rise = sclk_s && !sclk_d;
  assign fall = !sclk_s && sclk_d;

  always_comb begin
    case (peek_sel)
      SEL_CTRL: rd_word = SH_W'(status_in) << (SH_W - STS_W);
      SEL_CFG:  rd_word = SH_W'(cfg_q)     << (SH_W - CFG_W);
      SEL_FLT:  rd_word = SH_W'(filt_q)    << (SH_W - FLT_W);
      default:  rd_word = SH_W'(conv_data) << (SH_W - DAT_W);
    endcase
  end

  regport_ones #(.ONES_RESET(ONES_RESET)) u_ones (
    .clk(clk), .rst(rst), .csn_s(csn_s), .rise(rise), .din_s(din_s), .fire(soft_rst));

  regport_fsm #(.SH_W(SH_W), .CFG_W(CFG_W), .FLT_W(FLT_W), .DAT_W(DAT_W), .STS_W(STS_W)) u_fsm (
    .clk(clk), .rst(rst), .soft_rst(soft_rst), .csn_s(csn_s), .din_s(din_s),
    .rise(rise), .fall(fall), .rd_word(rd_word), .peek_sel(peek_sel),
    .cmd_stb(cmd_stb), .cmd_stby(cmd_stby), .cmd_osc(cmd_osc),
    .wr_stb(wr_stb), .wr_sel(wr_sel), .wr_data(wr_data),
    .dout(dout), .dout_en(dout_en));

  regport_regs #(.SH_W(SH_W), .CFG_W(CFG_W), .FLT_W(FLT_W),
                 .CFG_DEF(CFG_DEF), .FLT_DEF(FLT_DEF)) u_regs (
    .clk(clk), .rst(rst), .soft_rst(soft_rst), .cmd_stb(cmd_stb),
    .cmd_stby(cmd_stby), .cmd_osc(cmd_osc), .wr_stb(wr_stb), .wr_sel(wr_sel),
    .wr_data(wr_data), .cfg_q(cfg_q), .filt_q(filt_q),
    .standby(standby), .osc_stop(osc_stop));
endmodule

// File: tb/regport_serial_bench.sv
module regport_serial_bench;
  localparam int HALF = 8;  // fabric clocks per serial half period

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cs_n = 1'b1, sclk = 1'b0, din = 1'b0;
  logic [7:0]  status_in = 8'hA5;
  logic [15:0] conv_data = 16'hBEEF;
  logic        dout, dout_en, standby, osc_stop;
  logic [23:0] cfg_q;
  logic [7:0]  filt_q;
  int checks = 0, failures = 0;
  bit done = 0;

  always #4 clk = ~clk;

  regport_serial u_regport_serial (
    .clk(clk), .rst(rst), .cs_n(cs_n), .sclk(sclk), .din(din),
    .status_in(status_in), .conv_data(conv_data), .dout(dout), .dout_en(dout_en),
    .cfg_q(cfg_q), .filt_q(filt_q), .standby(standby), .osc_stop(osc_stop));

  typedef struct packed {
    logic [7:0]  cmd;
    logic [4:0]  n;
    logic [23:0] wd;
    logic [23:0] exp;
    logic [3:0]  req;
  } vec_t;

  // cmd bit6=1 means read; write rows compare the port of the selected register
  localparam vec_t VEC [8] = '{
    '{8'h01, 5'd24, 24'h123456, 24'h123456, 4'd5},  // R5 cfg write
    '{8'h41, 5'd24, 24'h000000, 24'h123456, 4'd6},  // R6 cfg read
    '{8'h02, 5'd8,  24'h00000D, 24'h00000D, 4'd5},  // R5 filt write
    '{8'h42, 5'd8,  24'h000000, 24'h00000D, 4'd6},  // R6 filt read
    '{8'h40, 5'd8,  24'h000000, 24'h0000A5, 4'd6},  // R6 status read
    '{8'h43, 5'd16, 24'h000000, 24'h00BEEF, 4'd6},  // R6 conversion read
    '{8'h03, 5'd16, 24'h00C0DE, 24'h123456, 4'd7},  // R7 discarded write
    '{8'h41, 5'd24, 24'h000000, 24'h123456, 4'd7}   // R7 cfg intact
  };

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic xfer(input logic [31:0] tx, input int n, output logic [31:0] rx);
    rx = '0;
    for (int i = n - 1; i >= 0; i--) begin
      din = tx[i];
      repeat (HALF) @(negedge clk);
      rx = {rx[30:0], dout};
      sclk = 1'b1;
      repeat (HALF) @(negedge clk);
      sclk = 1'b0;
    end
    din = 1'b0;
  endtask

  task automatic open_cs();
    cs_n = 1'b0;
    repeat (HALF) @(negedge clk);
  endtask

  task automatic close_cs();
    repeat (HALF) @(negedge clk);
    cs_n = 1'b1;
    repeat (HALF) @(negedge clk);
  endtask

  task automatic txn(input logic [7:0] cmd, input int n, input logic [23:0] wd,
                     output logic [31:0] rx);
    logic [31:0] junk;
    open_cs();
    xfer({24'h0, cmd}, 8, junk);
    if (n > 0) xfer({8'h0, wd}, n, rx);
    else rx = '0;
    close_cs();
  endtask

  initial begin
    logic [31:0] rx, obs;
    repeat (5) @(negedge clk);
    rst = 1'b0;
    repeat (5) @(negedge clk);

    // R1 reset state
    chk("R1 reset outputs", {dout, dout_en, standby, osc_stop}, 4'b0000);
    chk("R1 reset cfg", cfg_q, 24'h0);
    chk("R1 reset filt", filt_q, 8'h45);

    // table walk: R5 R6 R7
    foreach (VEC[i]) begin
      txn(VEC[i].cmd, VEC[i].n, VEC[i].wd, rx);
      if (VEC[i].cmd[6]) obs = rx;
      else if (VEC[i].cmd[1:0] == 2'b10) obs = {24'h0, filt_q};
      else obs = {8'h0, cfg_q};
      chk($sformatf("R%0d vector %0d", VEC[i].req, i), obs, {8'h0, VEC[i].exp});
    end

    // R6 dout_en during phase, quiet after
    open_cs();
    xfer(32'h43, 8, rx);
    repeat (HALF) @(negedge clk);
    chk("R6 dout_en in read phase", dout_en, 1'b1);
    xfer(0, 16, rx);
    chk("R6 conversion data", rx, 32'hBEEF);
    repeat (HALF) @(negedge clk);
    chk("R6 quiet after phase", {dout_en, dout}, 2'b00);
    close_cs();

    // R2 leading ones ignored
    open_cs();
    xfer(32'h1F, 5, rx);
    xfer(32'h42, 8, rx);
    xfer(0, 8, rx);
    close_cs();
    chk("R2 gate ones skipped", rx, 32'h0D);

    // R3 control bits
    txn(8'h30, 0, 0, rx);
    chk("R3 standby+osc set", {standby, osc_stop}, 2'b11);
    txn(8'h20, 0, 0, rx);
    chk("R3 standby only", {standby, osc_stop}, 2'b10);
    txn(8'h00, 0, 0, rx);
    chk("R3 cleared", {standby, osc_stop}, 2'b00);

    // R4 reserved bits nonzero
    txn(8'h24, 0, 0, rx);
    chk("R4 bad cmd keeps standby", standby, 1'b0);
    txn(8'h0E, 8, 24'hFF, rx);
    chk("R4 bad write keeps filt", filt_q, 8'h0D);

    // R8 back-to-back without releasing cs
    open_cs();
    xfer(32'h02, 8, rx);
    xfer(32'h5A, 8, rx);
    xfer(32'h42, 8, rx);
    xfer(0, 8, rx);
    close_cs();
    chk("R8 back-to-back read", rx, 32'h5A);

    // R10 abort mid write
    open_cs();
    xfer(32'h01, 8, rx);
    xfer(32'hABC, 12, rx);
    cs_n = 1'b1;
    repeat (HALF) @(negedge clk);
    chk("R10 partial write dropped", cfg_q, 24'h123456);
    txn(8'h41, 24, 0, rx);
    chk("R10 next read works", rx, 32'h123456);

    // R9 recovery run
    txn(8'h30, 0, 0, rx);
    open_cs();
    xfer(32'hFFFFFFFF, 31, rx);
    close_cs();
    chk("R9 31 ones no effect", {standby, osc_stop, filt_q, cfg_q}, {2'b11, 8'h5A, 24'h123456});
    open_cs();
    xfer(32'hFFFFFFFF, 32, rx);
    close_cs();
    chk("R9 32 ones restore", {standby, osc_stop, filt_q, cfg_q}, {2'b00, 8'h45, 24'h0});
    txn(8'h42, 8, 0, rx);
    chk("R9 port usable after", rx, 32'h45);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule